// File: doc/BRIEF.md
# Dual-Width Add/Subtract Unit with Condition Flags

This block is the arithmetic core of an 8-bit accumulator processor. It adds or subtracts byte operands, adds or subtracts 16-bit register-pair operands, and adds a sign-extended byte offset to a 16-bit value. Every operation produces a wrapped result and four condition flags: zero, subtract, half-carry and carry. For subtraction, half-carry and carry are borrow indications. The arithmetic is purely combinational.

A registered stage captures the result and flags on an enable strobe. The rest of the processor gets a stable copy that changes only when an operation is issued. Fetching operands, decoding instructions and writing results back are left to the surrounding core.

Top module: `dual_alu`

## Requirements
- R1: A synchronous active-low reset clears `result` and `flags_out` to zero at the rising edge where `rst_n` is low.
- R2: Result and flags are captured at a rising edge where `en` is high and are visible from that edge. While `en` is low, both outputs hold their values whatever the other inputs do.
- R3: The flag vector is ordered as bit 3 zero, bit 2 subtract, bit 1 half-carry and bit 0 carry.
  - Byte add (`op`=0) adds `opa[7:0]` and `opb[7:0]`, and the upper byte of `result` is zero.
  - Zero is set when the wrapped byte result is 0, and subtract is cleared.
  - Half-carry is the carry out of bit 3 and carry is the carry out of bit 7.
- R4: Byte subtract (`op`=1) gives `opa[7:0]-opb[7:0]` modulo 256, with the upper byte zero.
  - Subtract is set, and zero is set when the result is 0.
  - Half-carry is set when the low nibble of `opb` exceeds that of `opa`, and carry is set when `opb[7:0]` exceeds `opa[7:0]`.
- R5: Word add (`op`=2) gives `opa+opb` modulo 65536, and subtract is cleared.
  - Half-carry is the carry out of bit 11 and carry is the carry out of bit 15.
  - Zero is copied from `flags_in[3]`.
- R6: Word subtract (`op`=3) gives `opa-opb` modulo 65536, with subtract set and zero set on a result of 0.
  - Half-carry is set when `opb[11:0]` exceeds `opa[11:0]`.
  - Carry is set when `opb` exceeds `opa`.
- R7: Offset add (`op`=4) adds `opa` to `opb[7:0]` sign-extended to 16 bits.
  - Half-carry and carry come from the unsigned add of `opa[7:0]` and `opb[7:0]`, out of bit 3 and out of bit 7.
  - Zero and subtract are cleared.
- R8: The unused codes 5 to 7 give a zero result and copy `flags_in` to `flags_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Capture strobe for the output register |
| op | input | 3 | Operation code (0 byte add, 1 byte sub, 2 word add, 3 word sub, 4 offset add) |
| opa | input | 16 | First operand (minuend) |
| opb | input | 16 | Second operand (subtrahend or offset) |
| flags_in | input | 4 | Current flags {Z,N,H,C} |
| result | output | 16 | Registered result |
| flags_out | output | 4 | Registered flags {Z,N,H,C} |

## Verification
Each result and flag set is due exactly one rising edge after the operation is presented with `en` high. The bench drives the inputs at a falling edge and compares at the next falling edge, after the single capturing edge. The reference model runs each operation on plain integers and keeps the last expected pair. For the hold checks, the bench changes the inputs with `en` low and expects the outputs still to match the previous pair one edge later.

// File: rtl/alu_pkg.sv
// Package: shared widths, operation codes and flag layout for the
// dual-width add/subtract unit. Assumes flags are ordered {Z,N,H,C}.
package alu_pkg;

    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 16;
    localparam int BYTE_HB = 4;   // half-carry boundary for byte ops
    localparam int WORD_HB = 12;  // half-carry boundary for word ops
    localparam int OP_W    = 3;
    localparam int FLAG_W  = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD8  = 3'd0,
        OP_SUB8  = 3'd1,
        OP_ADD16 = 3'd2,
        OP_SUB16 = 3'd3,
        OP_ADDS8 = 3'd4,
        OP_RSV5  = 3'd5,
        OP_RSV6  = 3'd6,
        OP_RSV7  = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } alu_flags_t;

endpackage

// File: rtl/alu_addsub.sv
// Module: alu_addsub
// Combinational add or subtract of width W. It reports the carry or
// borrow at a half boundary HB and at the full width, and whether the
// wrapped result is zero.
// Assumes: unsigned operands. In subtract mode, "borrow" means the
// subtrahend's field is larger than the minuend's field.
module alu_addsub #(
    parameter int W  = 8,
    parameter int HB = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] res,
    output logic         half,
    output logic         carry,
    output logic         zero
);

    localparam int FULL_W = W + 1;
    localparam int PART_W = HB + 1;

    logic [FULL_W-1:0] sum_full;
    logic [PART_W-1:0] sum_part;
    logic [W-1:0]      diff;

    // Form the sum, the low-field sum and the difference in parallel.
    always_comb begin
        sum_full = {1'b0, a} + {1'b0, b};
        sum_part = {1'b0, a[HB-1:0]} + {1'b0, b[HB-1:0]};
        diff     = a - b;
    end

    // Pick the result and the carry or borrow indications for the mode.
    always_comb begin
        if (sub) begin
            res   = diff;
            half  = (b[HB-1:0] > a[HB-1:0]);
            carry = (b > a);
        end else begin
            res   = sum_full[W-1:0];
            half  = sum_part[HB];
            carry = sum_full[W];
        end
    end

    // Detect a zero wrapped result.
    always_comb begin
        zero = (res == '0);
    end

endmodule

// File: rtl/alu_core.sv
// Module: alu_core
// Combinational operation select for the dual-width unit. A byte-wide
// adder serves byte ops and the low-byte flags of the offset add. A
// word-wide adder serves word ops and the offset add's 16-bit sum.
// Assumes: WORD_W > BYTE_W. The upper operand bits are ignored for byte ops.
module alu_core
    import alu_pkg::*;
#(
    parameter int BW  = BYTE_W,
    parameter int WW  = WORD_W,
    parameter int BHB = BYTE_HB,
    parameter int WHB = WORD_HB
) (
    input  alu_op_e     op,
    input  logic [WW-1:0] opa,
    input  logic [WW-1:0] opb,
    input  alu_flags_t  flags_in,
    output logic [WW-1:0] res,
    output alu_flags_t  flags
);

    localparam int EXT_W = WW - BW;

    logic [BW-1:0] b_res;
    logic          b_half, b_carry, b_zero, b_sub;
    logic [WW-1:0] w_res, w_opb;
    logic          w_half, w_carry, w_zero, w_sub;

    // Derive the mode of each adder and the word adder's second operand.
    always_comb begin
        b_sub = (op == OP_SUB8);
        w_sub = (op == OP_SUB16);
        if (op == OP_ADDS8)
            w_opb = {{EXT_W{opb[BW-1]}}, opb[BW-1:0]};
        else
            w_opb = opb;
    end

    alu_addsub #(.W(BW), .HB(BHB)) byte_unit (
        .a     (opa[BW-1:0]),
        .b     (opb[BW-1:0]),
        .sub   (b_sub),
        .res   (b_res),
        .half  (b_half),
        .carry (b_carry),
        .zero  (b_zero)
    );

    alu_addsub #(.W(WW), .HB(WHB)) word_unit (
        .a     (opa),
        .b     (w_opb),
        .sub   (w_sub),
        .res   (w_res),
        .half  (w_half),
        .carry (w_carry),
        .zero  (w_zero)
    );

    // Route the result and flags for the selected operation.
    always_comb begin
        res   = '0;
        flags = flags_in;
        unique case (op)
            OP_ADD8, OP_SUB8: begin
                res   = {{EXT_W{1'b0}}, b_res};
                flags = '{z: b_zero, n: b_sub, h: b_half, c: b_carry};
            end
            OP_ADD16: begin
                res   = w_res;
                flags = '{z: flags_in.z, n: 1'b0, h: w_half, c: w_carry};
            end
            OP_SUB16: begin
                res   = w_res;
                flags = '{z: w_zero, n: 1'b1, h: w_half, c: w_carry};
            end
            OP_ADDS8: begin
                res   = w_res;
                flags = '{z: 1'b0, n: 1'b0, h: b_half, c: b_carry};
            end
            default: begin
                res   = '0;
                flags = flags_in;
            end
        endcase
    end

endmodule

// File: rtl/alu_out_reg.sv
// Module: alu_out_reg
// Capture register for the result and flags. It loads on en, holds
// otherwise and clears on the synchronous active-low reset.
// Assumes: one clock domain.
module alu_out_reg #(
    parameter int DW = 16,
    parameter int FW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [DW-1:0] d_res,
    input  logic [FW-1:0] d_flags,
    output logic [DW-1:0] q_res,
    output logic [FW-1:0] q_flags
);

    // Load, hold or clear the captured result and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_res   <= '0;
            q_flags <= '0;
        end else if (en) begin
            q_res   <= d_res;
            q_flags <= d_flags;
        end
    end

endmodule

// File: rtl/dual_alu.sv
// Module: dual_alu (top)
// Dual-width add/subtract unit with condition flags and a registered
// output stage. Results appear one clock after issue with en high.
// Assumes: flags ordered {Z,N,H,C}, and op codes as in alu_pkg.
module dual_alu
    import alu_pkg::*;
#(
    parameter int BW  = BYTE_W,
    parameter int WW  = WORD_W,
    parameter int BHB = BYTE_HB,
    parameter int WHB = WORD_HB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [OP_W-1:0]   op,
    input  logic [WW-1:0]     opa,
    input  logic [WW-1:0]     opb,
    input  logic [FLAG_W-1:0] flags_in,
    output logic [WW-1:0]     result,
    output logic [FLAG_W-1:0] flags_out
);

    alu_op_e       op_c;
    alu_flags_t    fin_c;
    logic [WW-1:0] core_res;
    alu_flags_t    core_flags;

    // Reinterpret the raw port vectors as package types.
    always_comb begin
        op_c  = alu_op_e'(op);
        fin_c = alu_flags_t'(flags_in);
    end

    alu_core #(.BW(BW), .WW(WW), .BHB(BHB), .WHB(WHB)) core_i (
        .op       (op_c),
        .opa      (opa),
        .opb      (opb),
        .flags_in (fin_c),
        .res      (core_res),
        .flags    (core_flags)
    );

    alu_out_reg #(.DW(WW), .FW(FLAG_W)) oreg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .d_res   (core_res),
        .d_flags (core_flags),
        .q_res   (result),
        .q_flags (flags_out)
    );

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (result == '0) && (flags_out == '0));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(result) && $stable(flags_out));

    // R3
    add8_n_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op_c == OP_ADD8) |=> (flags_out[2] == 1'b0) && (result[WW-1:BW] == '0));

    // R4
    sub8_borrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op_c == OP_SUB8) |=>
            (flags_out[0] == ($past(opb[BW-1:0]) > $past(opa[BW-1:0]))) && flags_out[2]);

    // R5
    add16_zero_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op_c == OP_ADD16) |=> (flags_out[3] == $past(flags_in[3])) && !flags_out[2]);

    // R6
    sub16_borrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op_c == OP_SUB16) |=>
            (flags_out[0] == ($past(opb) > $past(opa))) && flags_out[2]);

    // R7
    adds8_zn_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op_c == OP_ADDS8) |=> (flags_out[3:2] == 2'b00));

    // R8
    spare_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op_c > OP_ADDS8) |=> (result == '0) && (flags_out == $past(flags_in)));

endmodule

// File: tb/dual_alu_tb_top.sv
// Bench for dual_alu. The reference model works on integers. Every
// operation is issued at a falling edge and checked at the next
// falling edge.
module dual_alu_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [15:0] opa = 16'd0, opb = 16'd0;
    logic [3:0]  flags_in = 4'd0;
    logic [15:0] result;
    logic [3:0]  flags_out;

    int n_checks = 0;
    int n_fail   = 0;
    logic [15:0] last_res = 16'd0;
    logic [3:0]  last_flg = 4'd0;

    dual_alu dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .op(op), .opa(opa), .opb(opb),
        .flags_in(flags_in), .result(result), .flags_out(flags_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference behaviour for one operation, computed on integers.
    function automatic void model(input logic [2:0] o, input logic [15:0] a, b,
                                  input logic [3:0] fi,
                                  output logic [15:0] r, output logic [3:0] f);
        int ai, bi, s, sb;
        bit z, n, h, c;
        z = 0; n = 0; h = 0; c = 0; r = 16'd0;
        case (o)
            3'd0: begin
                ai = int'(a[7:0]); bi = int'(b[7:0]); s = ai + bi;
                r = 16'(s % 256); z = (s % 256) == 0;
                h = ((ai % 16) + (bi % 16)) > 15; c = s > 255;
            end
            3'd1: begin
                ai = int'(a[7:0]); bi = int'(b[7:0]); s = ai - bi;
                r = 16'((s + 256) % 256); z = (r == 16'd0); n = 1;
                h = (bi % 16) > (ai % 16); c = bi > ai;
            end
            3'd2: begin
                ai = int'(a); bi = int'(b); s = ai + bi;
                r = 16'(s % 65536); z = fi[3];
                h = ((ai % 4096) + (bi % 4096)) > 4095; c = s > 65535;
            end
            3'd3: begin
                ai = int'(a); bi = int'(b); s = ai - bi;
                r = 16'((s + 65536) % 65536); z = (r == 16'd0); n = 1;
                h = (bi % 4096) > (ai % 4096); c = bi > ai;
            end
            3'd4: begin
                ai = int'(a); bi = int'(b[7:0]);
                sb = (bi > 127) ? bi - 256 : bi;
                s = ai + sb;
                r = 16'((s + 65536) % 65536);
                h = (((ai % 256) % 16) + (bi % 16)) > 15;
                c = ((ai % 256) + bi) > 255;
            end
            default: begin
                r = 16'd0; {z, n, h, c} = fi;
            end
        endcase
        if (o <= 3'd4) f = {z, n, h, c};
        else f = fi;
    endfunction

    function automatic string req_of(input logic [2:0] o);
        case (o)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string req, input logic [15:0] er, input logic [3:0] ef);
        n_checks++;
        if (result !== er || flags_out !== ef) begin
            n_fail++;
            $display("FAIL %s: result=%h flags=%b expected result=%h flags=%b",
                     req, result, flags_out, er, ef);
        end
    endtask

    // Issue one operation and check it after the capturing edge.
    task automatic run_op(input logic [2:0] o, input logic [15:0] a, b,
                          input logic [3:0] fi);
        logic [15:0] er;
        logic [3:0]  ef;
        model(o, a, b, fi, er, ef);
        @(negedge clk);
        op = o; opa = a; opb = b; flags_in = fi; en = 1'b1;
        @(negedge clk);
        en = 1'b0;
        check(req_of(o), er, ef);
        last_res = er; last_flg = ef;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD * WATCHDOG);
        n_fail++; n_checks++;
        $display("FAIL watchdog: result=%h flags=%b expected completion", result, flags_out);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", 16'h0000, 4'b0000);     // R1 reset state
        rst_n = 1'b1;

        run_op(3'd0, 16'h0008, 16'h0008, 4'b0000);  // R3 half-carry, expect 0010 H
        run_op(3'd0, 16'h0080, 16'h0080, 4'b0000);  // R3 wrap, expect 0000 Z C
        run_op(3'd0, 16'hAB08, 16'hCD08, 4'b1111);  // R3 upper bytes ignored
        run_op(3'd1, 16'h0008, 16'h0008, 4'b0000);  // R4 equal, Z N
        run_op(3'd1, 16'h0010, 16'h0018, 4'b0000);  // R4 expect F8 N H C
        run_op(3'd2, 16'h0800, 16'h0800, 4'b1000);  // R5 expect 1000 H, Z kept set
        run_op(3'd2, 16'h8000, 16'h8000, 4'b0000);  // R5 zero result, Z kept clear, C
        run_op(3'd3, 16'h1000, 16'h4800, 4'b0000);  // R6 expect C800 N H C
        run_op(3'd3, 16'h1234, 16'h1234, 4'b0000);  // R6 zero result sets Z
        run_op(3'd4, 16'h0028, 16'h00D8, 4'b1111);  // R7 40 + (-40): 0000, Z clear, H C
        run_op(3'd4, 16'h1000, 16'h0080, 4'b0000);  // R7 negative offset: 0F80
        run_op(3'd4, 16'h00FF, 16'hFF01, 4'b0000);  // R7 only opb[7:0] used: 0100 H C
        run_op(3'd5, 16'h1234, 16'h5678, 4'b1010);  // R8 spare code
        run_op(3'd7, 16'hFFFF, 16'hFFFF, 4'b0101);  // R8 spare code

        // R2: with en low, new inputs must not change the outputs
        run_op(3'd3, 16'h1000, 16'h4800, 4'b0000);
        @(negedge clk);
        op = 3'd0; opa = 16'h0001; opb = 16'h0001; flags_in = 4'b1111; en = 1'b0;
        @(negedge clk);
        check("R2", last_res, last_flg);
        @(negedge clk);
        check("R2", last_res, last_flg);

        // Mixed operations against the model
        for (int i = 0; i < 400; i++) begin
            run_op(3'($urandom % 8), 16'($urandom), 16'($urandom), 4'($urandom));
        end

        // R1: reset during operation clears the outputs
        run_op(3'd1, 16'h0010, 16'h0018, 4'b0000);
        @(negedge clk);
        rst_n = 1'b0; en = 1'b1;
        @(negedge clk);
        check("R1", 16'h0000, 4'b0000);
        rst_n = 1'b1; en = 1'b0;

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule